// File: doc/BRIEF.md
# USB line-state change detector

This block watches the condition of a USB data-line pair, given as two synchronous flags: one that is high while both lines are low (single-ended zero) and one that is high while the bus is in the J state. It reduces each sample to one of three bus conditions: SE0, J or K. It then waits for the condition to settle. A condition counts as settled once it has held without change for one millisecond, measured as a parameterized number of clock cycles.

When a settled condition differs from the one accepted before it, the block raises a sticky change flag. Software clears the flag with a write-one strobe. An interrupt-enable input gates the flag onto the interrupt output. The most recently settled condition is always readable on a dedicated output. Higher layers use the flag to spot bus reset, resume, attach and data-line pulsing without polling the line flags.

Top module: `usb_line_watch`

## Requirements
- R1: The bus condition is decoded with SE0 taking priority: SE0 when `se0_i`=1, else J when `jstate_i`=1, else K. It is shown on `stable_state_o` with codes SE0=2'd0, J=2'd1, K=2'd2.
- R2: A new condition is sampled at some rising edge E0. If it is held unchanged, it is accepted at edge E0+CYCLES_PER_MS, and not before.
- R3: On acceptance, `stable_state_o` takes the new condition. `chg_flag_o` is set only if that condition differs from the previously accepted one. Settling again on the same condition leaves the flag at 0.
- R4: Any change of the decoded condition before acceptance restarts the full window from the new condition. A glitch that returns to the accepted condition raises no flag.
- R5: While `se0_i`=1, toggles of `jstate_i` are not a change. They neither restart nor shorten a window in progress, and they never raise the flag.
- R6: `chg_flag_o` stays set until a cycle with `clr_i`=1 clears it. If acceptance of a differing condition and `clr_i` fall on the same edge, the flag ends up set.
- R7: `irq_o` is `chg_flag_o` AND `irq_en_i`. The flag still sets while `irq_en_i`=0.
- R8: While `rst_n`=0, the accepted condition is SE0, the window is idle and `chg_flag_o`=0. A window in progress is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| se0_i | input | 1 | Both data lines low |
| jstate_i | input | 1 | Bus in J state (ignored while se0_i=1) |
| irq_en_i | input | 1 | Interrupt enable |
| clr_i | input | 1 | Write-one strobe that clears the change flag |
| chg_flag_o | output | 1 | Sticky line-state change flag |
| irq_o | output | 1 | Gated interrupt request |
| stable_state_o | output | 2 | Last accepted bus condition (0=SE0, 1=J, 2=K) |

## Verification
The hardest case to reach from the ports is a settling event that lands on exactly the same edge as a clear strobe, or a J toggle hidden inside a running SE0 window. The bench shortens the millisecond to 16 cycles. It then counts edges from the negative edge where it changes the inputs, so it can raise `clr_i` for exactly the acceptance edge, or flip `jstate_i` part-way through an SE0 window. Finally it checks that the flag appears on the very edge predicted from the first change.

// File: rtl/line_watch_pkg.sv
package line_watch_pkg;

  typedef enum logic [1:0] {
    LS_SE0 = 2'd0,
    LS_J   = 2'd1,
    LS_K   = 2'd2
  } line_t;

  // SE0 dominates; the J flag only matters when the lines are not both low.
  function automatic line_t classify(input logic se0, input logic jst);
    if (se0)      return LS_SE0;
    else if (jst) return LS_J;
    else          return LS_K;
  endfunction

  // One step of the settle counter: a reload wins, otherwise count down to 0.
  function automatic int unsigned settle_next(input int unsigned cnt,
                                              input logic reload,
                                              input int unsigned window);
    if (reload)        return window;
    else if (cnt != 0) return cnt - 1;
    else               return 0;
  endfunction

endpackage

// File: rtl/line_sampler.sv
module line_sampler
  import line_watch_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  se0_i,
  input  logic  jstate_i,
  output line_t cur_o,
  output logic  change_o
);

  line_t now_w;
  line_t cur_q;

  assign now_w    = classify(se0_i, jstate_i);
  assign change_o = (now_w != cur_q);
  assign cur_o    = cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cur_q <= LS_SE0;
    else        cur_q <= now_w;
  end

  // R5: with the lines held at SE0, the tracked condition cannot leave SE0
  a_r5_se0_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == LS_SE0 && se0_i) |=> (cur_q == LS_SE0));

  // R1: the tracked condition is always one of the three legal codes
  a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q != 2'd3));

endmodule

// File: rtl/settle_timer.sv
module settle_timer
  import line_watch_pkg::*;
#(
  parameter int unsigned CYCLES_PER_MS = 48000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload_i,
  output logic expire_o,
  output logic busy_o
);

  localparam int unsigned CW = $clog2(CYCLES_PER_MS + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign cnt_d    = CW'(settle_next(int'(cnt_q), reload_i, CYCLES_PER_MS));
  assign expire_o = (cnt_q == CW'(1)) && !reload_i;
  assign busy_o   = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: an undisturbed running window counts down by exactly one
  a_r2_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !reload_i) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  // R4: a change always restarts the full window
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> (cnt_q == CW'(CYCLES_PER_MS)));

  // R2: the count never exceeds the window length
  a_r2_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= CW'(CYCLES_PER_MS)));

endmodule

// File: rtl/change_flag.sv
module change_flag
  import line_watch_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  expire_i,
  input  line_t cur_i,
  input  logic  clr_i,
  output line_t stable_o,
  output logic  set_o,
  output logic  flag_o
);

  line_t stable_q;
  logic  flag_q;

  assign set_o    = expire_i && (cur_i != stable_q);
  assign stable_o = stable_q;
  assign flag_o   = flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stable_q <= LS_SE0;
      flag_q   <= 1'b0;
    end else begin
      if (expire_i) stable_q <= cur_i;
      if (set_o)      flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  // R6: the flag stays set unless a clear strobe arrives
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);

  // R3: settling on the same condition never raises the flag
  a_r3_same_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_i && cur_i == stable_q && !flag_q) |=> !flag_q);

  // R3: the accepted condition moves only on acceptance
  a_r3_stable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !expire_i |=> $stable(stable_q));

endmodule

// File: rtl/usb_line_watch.sv
module usb_line_watch
  import line_watch_pkg::*;
#(
  parameter int unsigned CYCLES_PER_MS = 48000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       se0_i,
  input  logic       jstate_i,
  input  logic       irq_en_i,
  input  logic       clr_i,
  output logic       chg_flag_o,
  output logic       irq_o,
  output logic [1:0] stable_state_o
);

  line_t cur_w;
  line_t stable_w;
  logic  change_w;
  logic  expire_w;
  logic  busy_w;
  logic  set_w;

  line_sampler u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .se0_i    (se0_i),
    .jstate_i (jstate_i),
    .cur_o    (cur_w),
    .change_o (change_w)
  );

  settle_timer #(.CYCLES_PER_MS(CYCLES_PER_MS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .reload_i (change_w),
    .expire_o (expire_w),
    .busy_o   (busy_w)
  );

  change_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .expire_i (expire_w),
    .cur_i    (cur_w),
    .clr_i    (clr_i),
    .stable_o (stable_w),
    .set_o    (set_w),
    .flag_o   (chg_flag_o)
  );

  assign irq_o          = chg_flag_o && irq_en_i;
  assign stable_state_o = stable_w;

  // R2: the flag rises only on the edge where a window expired
  a_r2_rise_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_flag_o) |-> $past(expire_w));

  // R4: acceptance only happens with a window running
  a_r4_expire_busy: assert property (@(posedge clk) disable iff (!rst_n)
    expire_w |-> busy_w);

  // R7: a disabled interrupt keeps the output low
  a_r7_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_i |-> !irq_o);

  // R6: a set event that coincides with a clear leaves the flag set
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_w && clr_i) |=> chg_flag_o);

endmodule

// File: tb/tb_usb_line_watch.sv
module tb_usb_line_watch;

  localparam int unsigned CPM = 16;

  logic clk = 1'b0;
  logic rst_n, se0, jst, en, clr;
  logic chg, irq;
  logic [1:0] st;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  usb_line_watch #(.CYCLES_PER_MS(CPM)) dut (
    .clk(clk), .rst_n(rst_n), .se0_i(se0), .jstate_i(jst),
    .irq_en_i(en), .clr_i(clr), .chg_flag_o(chg), .irq_o(irq),
    .stable_state_o(st)
  );

  // each entry: {se0, jstate, expected stable code [1:0], expected flag}
  localparam logic [4:0] VEC [8] = '{
    {1'b0, 1'b1, 2'd1, 1'b1},  // SE0 -> J
    {1'b0, 1'b0, 2'd2, 1'b1},  // J -> K
    {1'b1, 1'b0, 2'd0, 1'b1},  // K -> SE0
    {1'b1, 1'b1, 2'd0, 1'b0},  // J flag raised under SE0: no change
    {1'b0, 1'b0, 2'd2, 1'b1},  // SE0 -> K
    {1'b0, 1'b1, 2'd1, 1'b1},  // K -> J
    {1'b1, 1'b1, 2'd0, 1'b1},  // J -> SE0 with J flag still high
    {1'b0, 1'b1, 2'd1, 1'b1}   // SE0 -> J
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_clr();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; se0 = 1'b1; jst = 1'b0; en = 1'b0; clr = 1'b0;
    wait_n(3);
    // R8: reset state
    chk("R8 reset flag", chg, 0);
    chk("R8 reset state", st, 0);
    chk("R8 reset irq", irq, 0);
    rst_n = 1'b1;
    wait_n(CPM + 4);
    chk("R3 SE0 held after reset, no flag", chg, 0);

    // table walk: R1 R2 R3 R5 R6
    for (int i = 0; i < 8; i++) begin
      se0 = VEC[i][4];
      jst = VEC[i][3];
      wait_n(CPM);
      if (VEC[i][0]) chk("R2 no flag before window ends", chg, 0);
      wait_n(1);
      chk("R2/R3 flag after window", chg, int'(VEC[i][0]));
      chk("R1 stable code", st, int'(VEC[i][2:1]));
      pulse_clr();
      chk("R6 clear strobe", chg, 0);
    end

    // R4: glitch to K and back to the accepted J
    jst = 1'b0; wait_n(5); jst = 1'b1;
    wait_n(CPM + 3);
    chk("R4 glitch no flag", chg, 0);
    chk("R4 glitch state kept", st, 1);

    // R4: partial K then SE0; window counts from the SE0 edge
    jst = 1'b0; wait_n(6); se0 = 1'b1;
    wait_n(CPM);
    chk("R4 restarted window not early", chg, 0);
    wait_n(1);
    chk("R4 flag after restarted window", chg, 1);
    chk("R4 state SE0", st, 0);
    pulse_clr();

    // R5: go to K, then SE0 with a J toggle mid-window
    se0 = 1'b0; jst = 1'b0; wait_n(CPM + 1); pulse_clr();
    se0 = 1'b1;
    wait_n(6); jst = 1'b1;
    wait_n(3); jst = 1'b0;
    wait_n(CPM - 9);
    chk("R5 no early flag", chg, 0);
    wait_n(1);
    chk("R5 flag not delayed by J toggle", chg, 1);
    pulse_clr();

    // R6 + R7: set and clear on the same edge, interrupt gating
    se0 = 1'b0; jst = 1'b1;
    wait_n(CPM);
    clr = 1'b1;
    wait_n(1);
    clr = 1'b0;
    chk("R6 set wins over clear", chg, 1);
    chk("R7 irq off while disabled", irq, 0);
    en = 1'b1; #1;
    chk("R7 irq on when enabled", irq, 1);
    wait_n(1);
    pulse_clr();
    chk("R7 irq drops on clear", irq, 0);

    // R8: reset during a running window
    jst = 1'b0;
    wait_n(5);
    rst_n = 1'b0; wait_n(2); rst_n = 1'b1;
    chk("R8 state after mid reset", st, 0);
    wait_n(CPM + 1);
    chk("R8 fresh window after reset", chg, 1);
    chk("R1 K accepted", st, 2);

    done = 1'b1;
    finish_run();
  end

endmodule